// File: doc/BRIEF.md
# Configurable Bidirectional GPIO Port

This block is one general-purpose I/O port of parameterised width (eight pins by default) that sits behind a small register bus. Software programs a direction, a polarity, an output style and output data per pin. The port then drives per-pin output enables and output values toward the pads, and it samples the pad inputs through a two-flop synchronizer. Reads of the input view return the synchronized pin levels after polarity inversion.

An output pin can hold a level, or it can fire a one-shot pulse of fixed length. In pulse mode, writing a 1 to the data bit starts the pulse, and the bit clears itself when the pulse ends. A snapshot register records the pin levels just after power-on. A two-bit mode register sets how the external reset pin acts. It decides whether that pin re-records the snapshot, and whether it returns the configuration registers to their defaults. A power-on reset always does both.

The bus is a single-cycle strobe interface. A write takes effect at the clock edge where `bus_wr` is high. A read registers the addressed value into `bus_rdata` at the edge where `bus_rd` is high.

Top module: `cfg_gpio_port`

## Requirements
- R1: After power-on reset, no pin is driven and the registers read as follows: output data 0x00, polarity 0xF0, direction 0xFF, style 0x00, mode 0x00. Address 7 always reads 0x00.
- R2: A direction bit of 1 makes its pin an input and a bit of 0 makes it an output. `pin_oe` equals the inverse of the direction register, and an input pin has `pin_out` low whatever its data bit holds.
- R3: For an output pin in level style (style bit 0), `pin_out` equals the data bit XOR the polarity bit. It changes in the cycle after the write edge.
- R4: A read of the output data register (address 1) returns the stored data flops, whatever the pins or the direction.
- R5: Address 0 returns the pin levels after two synchronizer stages, XOR the polarity register. It is read-only, so a write to it changes nothing.
- R6: With style bit 1, writing a 1 to the data bit drives the active level (the inverse of the polarity bit) for exactly PULSE_CYCLES clock cycles (16 by default). The pin then returns to its polarity level and the data bit reads 0. Writing a 0 ends the pulse at once.
- R7: The snapshot register (address 5) takes the pin levels present at the first clock edge after power-on release. It is read-only and holds its value afterwards.
- R8: With mode bit 1 set (address 6), holding the external reset pin low re-records the snapshot from the current pins. With mode bit 1 clear, the external reset pin leaves the snapshot unchanged.
- R9: With mode bit 0 set, holding the external reset pin low returns output data, polarity, direction and style to their R1 defaults. With mode bit 0 clear, they are unchanged. The mode register itself is cleared only by power-on reset.
- R10: The register addresses are: 0 input view, 1 output data, 2 polarity, 3 direction, 4 style, 5 snapshot, 6 mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| ext_rst_n | input | 1 | External reset pin, active low, synchronized internally |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | WIDTH | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | WIDTH | Registered read data |
| pin_in | input | WIDTH | Pad input levels |
| pin_oe | output | WIDTH | Per-pin output enable |
| pin_out | output | WIDTH | Per-pin output value |

## Verification
The hardest case to reach from the ports is the external reset pin acting under each mode setting. The snapshot must re-record only when mode bit 1 is set, and the configuration must revert only when mode bit 0 is set. The mode register must survive both cases. The bench first loads configuration values that differ from every default. It then pulses the external reset pin once with the mode clear, once with only the configuration bit set, and once with only the snapshot bit set. The pin levels differ from the power-on snapshot each time. After each pulse it reads every register back. The pulse length is checked by counting falling edges from the write edge to the last active cycle and to the first inactive cycle.

// File: rtl/cgp_pkg.sv
package cgp_pkg;

  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_VIEW  = 3'd0,
    A_DATA  = 3'd1,
    A_POL   = 3'd2,
    A_DIR   = 3'd3,
    A_STYLE = 3'd4,
    A_SNAP  = 3'd5,
    A_MODE  = 3'd6
  } cgp_addr_e;

  localparam int MODE_W        = 2;
  localparam int MODE_CFG_BIT  = 0;
  localparam int MODE_SNAP_BIT = 1;

  // value seen through the polarity stage, both directions
  function automatic logic pol_apply(input logic val, input logic inv);
    return val ^ inv;
  endfunction

  // pad value for one pin: undriven pins stay low
  function automatic logic pad_value(input logic data, input logic inv, input logic is_in);
    return is_in ? 1'b0 : pol_apply(data, inv);
  endfunction

endpackage

// File: rtl/cgp_sync.sv
module cgp_sync #(
  parameter int          W       = 8,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/cgp_pulse_lane.sv
module cgp_pulse_lane #(
  parameter int PULSE_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_clr,
  input  logic wr_hit,
  input  logic wr_bit,
  input  logic style,
  output logic data_q,
  output logic pulse_end
);

  localparam int             CW   = $clog2(PULSE_CYCLES + 1);
  localparam logic [CW-1:0]  LOAD = CW'(PULSE_CYCLES);
  localparam logic [CW-1:0]  ONE  = CW'(1);

  logic [CW-1:0] cnt;

  assign pulse_end = style && !cfg_clr && !wr_hit && (cnt == ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= 1'b0;
      cnt    <= '0;
    end else if (cfg_clr) begin
      data_q <= 1'b0;
      cnt    <= '0;
    end else if (wr_hit) begin
      data_q <= wr_bit;
      cnt    <= (style && wr_bit) ? LOAD : '0;
    end else if (!style) begin
      cnt <= '0;
    end else if (cnt != '0) begin
      cnt <= cnt - ONE;
      if (cnt == ONE) data_q <= 1'b0;
    end
  end

endmodule

// File: rtl/cgp_snapshot.sv
module cgp_snapshot #(
  parameter int W           = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         por_n,
  input  logic         ext_low,
  input  logic         snap_on_ext,
  input  logic [W-1:0] pins_s,
  output logic         capture,
  output logic [W-1:0] snap_q
);

  localparam int            WIN = SYNC_STAGES + 1;
  localparam int            CW  = $clog2(WIN + 1);
  localparam logic [CW-1:0] WIN_LOAD = CW'(WIN);

  logic [CW-1:0] win_cnt;

  // window covers the cycles needed for real pin values to reach pins_s
  assign capture = (win_cnt != '0) || (ext_low && snap_on_ext);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)              win_cnt <= WIN_LOAD;
    else if (win_cnt != '0)  win_cnt <= win_cnt - CW'(1);
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)       snap_q <= '0;
    else if (capture) snap_q <= pins_s;
  end

endmodule

// File: rtl/cfg_gpio_port.sv
module cfg_gpio_port
  import cgp_pkg::*;
#(
  parameter int             WIDTH        = 8,
  parameter int             SYNC_STAGES  = 2,
  parameter int             PULSE_CYCLES = 16,
  parameter logic [WIDTH-1:0] POL_RST    = 8'hF0
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              ext_rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WIDTH-1:0]  bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [WIDTH-1:0]  bus_rdata,
  input  logic [WIDTH-1:0]  pin_in,
  output logic [WIDTH-1:0]  pin_oe,
  output logic [WIDTH-1:0]  pin_out
);

  localparam logic [WIDTH-1:0] DIR_RST = '1;

  logic [WIDTH-1:0]  pol_q, dir_q, style_q, data_q, snap_q, pins_s, view;
  logic [WIDTH-1:0]  pulse_end;
  logic [MODE_W-1:0] mode_q;
  logic              ext_sync, ext_low, cfg_clr, snap_capture;
  logic              wr_data, wr_pol, wr_dir, wr_style, wr_mode;

  // pad and reset-pin synchronizers
  cgp_sync #(.W(WIDTH), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_pin_sync (
    .clk(clk), .rst_n(por_n), .d(pin_in), .q(pins_s));

  cgp_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_rst_sync (
    .clk(clk), .rst_n(por_n), .d(ext_rst_n), .q(ext_sync));

  assign ext_low = !ext_sync;
  assign cfg_clr = ext_low && mode_q[MODE_CFG_BIT];

  // write decode
  assign wr_data  = bus_wr && (bus_addr == A_DATA);
  assign wr_pol   = bus_wr && (bus_addr == A_POL);
  assign wr_dir   = bus_wr && (bus_addr == A_DIR);
  assign wr_style = bus_wr && (bus_addr == A_STYLE);
  assign wr_mode  = bus_wr && (bus_addr == A_MODE);

  // configuration registers
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      pol_q   <= POL_RST;
      dir_q   <= DIR_RST;
      style_q <= '0;
    end else if (cfg_clr) begin
      pol_q   <= POL_RST;
      dir_q   <= DIR_RST;
      style_q <= '0;
    end else begin
      if (wr_pol)   pol_q   <= bus_wdata;
      if (wr_dir)   dir_q   <= bus_wdata;
      if (wr_style) style_q <= bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)       mode_q <= '0;
    else if (wr_mode) mode_q <= bus_wdata[MODE_W-1:0];
  end

  // per-pin data flop with pulse timer, and pad drive
  for (genvar g = 0; g < WIDTH; g++) begin : g_lane
    cgp_pulse_lane #(.PULSE_CYCLES(PULSE_CYCLES)) u_lane (
      .clk      (clk),
      .rst_n    (por_n),
      .cfg_clr  (cfg_clr),
      .wr_hit   (wr_data),
      .wr_bit   (bus_wdata[g]),
      .style    (style_q[g]),
      .data_q   (data_q[g]),
      .pulse_end(pulse_end[g]));

    assign pin_oe[g]  = !dir_q[g];
    assign pin_out[g] = pad_value(data_q[g], pol_q[g], dir_q[g]);
    assign view[g]    = pol_apply(pins_s[g], pol_q[g]);
  end

  cgp_snapshot #(.W(WIDTH), .SYNC_STAGES(SYNC_STAGES)) u_snap (
    .clk        (clk),
    .por_n      (por_n),
    .ext_low    (ext_low),
    .snap_on_ext(mode_q[MODE_SNAP_BIT]),
    .pins_s     (pins_s),
    .capture    (snap_capture),
    .snap_q     (snap_q));

  // registered read port
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      case (bus_addr)
        A_VIEW:  bus_rdata <= view;
        A_DATA:  bus_rdata <= data_q;
        A_POL:   bus_rdata <= pol_q;
        A_DIR:   bus_rdata <= dir_q;
        A_STYLE: bus_rdata <= style_q;
        A_SNAP:  bus_rdata <= snap_q;
        A_MODE:  bus_rdata <= WIDTH'(mode_q);
        default: bus_rdata <= '0;
      endcase
    end
  end

endmodule

// File: rtl/cgp_port_chk.sv
module cgp_port_chk
  import cgp_pkg::*;
#(
  parameter int               WIDTH        = 8,
  parameter int               PULSE_CYCLES = 16,
  parameter logic [WIDTH-1:0] POL_RST      = 8'hF0
) (
  input logic              clk,
  input logic              por_n,
  input logic              cfg_clr,
  input logic              snap_capture,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [WIDTH-1:0]  bus_wdata,
  input logic [WIDTH-1:0]  pin_oe,
  input logic [WIDTH-1:0]  data_q,
  input logic [WIDTH-1:0]  pol_q,
  input logic [WIDTH-1:0]  dir_q,
  input logic [WIDTH-1:0]  style_q,
  input logic [MODE_W-1:0] mode_q,
  input logic [WIDTH-1:0]  snap_q,
  input logic [WIDTH-1:0]  pulse_end
);

  localparam int HW = $clog2(PULSE_CYCLES + 2);

  assert_dir_write_R2: assert property (@(posedge clk) disable iff (!por_n)
    (bus_wr && bus_addr == A_DIR && !cfg_clr) |=> (pin_oe == ~$past(bus_wdata)));

  assert_cfg_defaults_R9: assert property (@(posedge clk) disable iff (!por_n)
    cfg_clr |=> (dir_q == '1 && data_q == '0 && style_q == '0 && pol_q == POL_RST));

  assert_mode_kept_R9: assert property (@(posedge clk) disable iff (!por_n)
    !(bus_wr && bus_addr == A_MODE) |=> $stable(mode_q));

  assert_snap_hold_R7: assert property (@(posedge clk) disable iff (!por_n)
    !snap_capture |=> $stable(snap_q));

  for (genvar g = 0; g < WIDTH; g++) begin : g_pin
    logic [HW-1:0] hi_cnt;

    always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) hi_cnt <= '0;
      else if (bus_wr && (bus_addr == A_DATA || bus_addr == A_STYLE)) hi_cnt <= '0;
      else if (data_q[g] && style_q[g]) hi_cnt <= hi_cnt + HW'(1);
      else hi_cnt <= '0;
    end

    assert_pulse_clear_R6: assert property (@(posedge clk) disable iff (!por_n)
      pulse_end[g] |=> !data_q[g]);

    assert_pulse_len_R6: assert property (@(posedge clk) disable iff (!por_n)
      hi_cnt <= HW'(PULSE_CYCLES));
  end

endmodule

bind cfg_gpio_port cgp_port_chk #(
  .WIDTH(WIDTH), .PULSE_CYCLES(PULSE_CYCLES), .POL_RST(POL_RST)
) u_chk (
  .clk(clk), .por_n(por_n), .cfg_clr(cfg_clr), .snap_capture(snap_capture),
  .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .pin_oe(pin_oe),
  .data_q(data_q), .pol_q(pol_q), .dir_q(dir_q), .style_q(style_q),
  .mode_q(mode_q), .snap_q(snap_q), .pulse_end(pulse_end));

// File: tb/cfg_gpio_port_test.sv
`timescale 1ns/1ps
module cfg_gpio_port_test;

  logic       clk = 1'b0;
  logic       por_n, ext_rst_n, bus_wr, bus_rd;
  logic [2:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata, pin_in, pin_oe, pin_out;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #5 clk = ~clk;

  cfg_gpio_port uut (
    .clk(clk), .por_n(por_n), .ext_rst_n(ext_rst_n), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_oe(pin_oe), .pin_out(pin_out));

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  // driver: push the expected read value, monitor compares it
  task automatic rd_expect(input logic [2:0] a, input logic [7:0] e, input string tag);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic ext_pulse();
    @(negedge clk);
    ext_rst_n = 1'b0;
    repeat (5) @(negedge clk);
    ext_rst_n = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  task automatic finish_run();
    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_chk++; n_bad++;
      $display("FAIL R10 actual=%0d expected=0 reads left unanswered", exp_q.size());
    end
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      if (bus_rd) begin
        @(negedge clk);
        if (exp_q.size() == 0) begin
          n_chk++; n_bad++;
          $display("FAIL R10 actual=%02h expected=none unexpected read", bus_rdata);
        end else begin
          chk(bus_rdata, exp_q.pop_front(), tag_q.pop_front());
        end
      end
    end
  end

  // watchdog
  initial begin
    #2000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    por_n = 1'b0; ext_rst_n = 1'b1; bus_wr = 1'b0; bus_rd = 1'b0;
    bus_addr = '0; bus_wdata = '0; pin_in = 8'hA5;
    repeat (5) @(negedge clk);
    por_n = 1'b1;
    repeat (6) @(negedge clk);

    // R1 reset state
    chk(pin_oe, 8'h00, "R1 pin_oe after reset");
    rd_expect(3'd1, 8'h00, "R1 data reset");
    rd_expect(3'd2, 8'hF0, "R1 polarity reset");
    rd_expect(3'd3, 8'hFF, "R1 direction reset");
    rd_expect(3'd4, 8'h00, "R1 style reset");
    rd_expect(3'd6, 8'h00, "R1 mode reset");
    rd_expect(3'd7, 8'h00, "R1 unused address");
    rd_expect(3'd5, 8'hA5, "R7 power-on snapshot");

    // R4 / R2: data flops read back while all pins are inputs
    wr(3'd1, 8'h5A);
    chk(pin_oe, 8'h00, "R2 inputs not enabled");
    chk(pin_out, 8'h00, "R2 inputs not driven");
    rd_expect(3'd1, 8'h5A, "R4 data readback");

    // R3 level output under two polarity settings
    wr(3'd1, 8'h33);
    wr(3'd3, 8'h0F);
    chk(pin_oe, 8'hF0, "R2 oe from direction");
    wr(3'd2, 8'h05);
    chk(pin_out, 8'h30, "R3 level out pol 05");
    wr(3'd2, 8'hFF);
    chk(pin_out, 8'hC0, "R3 level out pol FF");
    rd_expect(3'd1, 8'h33, "R4 data not pin level");

    // R5 input view
    pin_in = 8'h3C;
    repeat (4) @(negedge clk);
    rd_expect(3'd0, 8'hC3, "R5 view inverted");
    wr(3'd2, 8'h00);
    rd_expect(3'd0, 8'h3C, "R5 view plain");
    wr(3'd0, 8'hFF);
    rd_expect(3'd0, 8'h3C, "R5 view write ignored");

    // R6 pulse output
    wr(3'd3, 8'hFC);
    wr(3'd2, 8'h02);
    wr(3'd4, 8'h03);
    wr(3'd1, 8'h03);
    chk(pin_out, 8'h01, "R6 pulse active first cycle");
    repeat (15) @(negedge clk);
    chk(pin_out, 8'h01, "R6 pulse active last cycle");
    @(negedge clk);
    chk(pin_out, 8'h02, "R6 pulse ended");
    rd_expect(3'd1, 8'h00, "R6 data self-cleared");
    wr(3'd1, 8'h01);
    chk(pin_out, 8'h03, "R6 second pulse active");
    repeat (3) @(negedge clk);
    wr(3'd1, 8'h00);
    chk(pin_out, 8'h02, "R6 pulse ended by write 0");
    repeat (20) @(negedge clk);
    chk(pin_out, 8'h02, "R6 stays inactive");

    // R9 external reset with config bit clear then set
    wr(3'd4, 8'h00);
    wr(3'd2, 8'h0F);
    wr(3'd3, 8'h00);
    wr(3'd1, 8'h55);
    ext_pulse();
    rd_expect(3'd2, 8'h0F, "R9 pol kept mode 0");
    rd_expect(3'd3, 8'h00, "R9 dir kept mode 0");
    rd_expect(3'd1, 8'h55, "R9 data kept mode 0");
    chk(pin_oe, 8'hFF, "R9 oe kept mode 0");
    rd_expect(3'd5, 8'hA5, "R8 snapshot kept mode 0");
    wr(3'd4, 8'h80);
    wr(3'd6, 8'h01);
    ext_pulse();
    rd_expect(3'd2, 8'hF0, "R9 pol restored");
    rd_expect(3'd3, 8'hFF, "R9 dir restored");
    rd_expect(3'd1, 8'h00, "R9 data restored");
    rd_expect(3'd4, 8'h00, "R9 style restored");
    rd_expect(3'd6, 8'h01, "R9 mode survives");
    chk(pin_oe, 8'h00, "R9 oe restored");
    rd_expect(3'd5, 8'hA5, "R8 snapshot kept mode 1");

    // R8 snapshot re-record on external reset
    wr(3'd6, 8'h02);
    wr(3'd2, 8'h11);
    ext_pulse();
    rd_expect(3'd5, 8'h3C, "R8 snapshot re-recorded");
    rd_expect(3'd2, 8'h11, "R9 pol kept mode 2");
    pin_in = 8'h81;
    repeat (5) @(negedge clk);
    rd_expect(3'd5, 8'h3C, "R7 snapshot holds");
    wr(3'd5, 8'h00);
    rd_expect(3'd5, 8'h3C, "R7 snapshot write ignored");

    finish_run();
  end

endmodule